// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns a fetch virtual address into a physical address, or into a fault code, for an instruction fetch unit. It sits beside a translation buffer. In the same cycle as the request it sends out the page number and address-space number to look up. It then takes the buffer's hit flag, the physical page number and the per-mode execute-permission mask back as combinational inputs. The outcome is registered, so the result appears one clock after the request together with a valid strobe.

Three address classes are handled. Fetches from privileged code, marked by the low bit of the fetch PC, are mapped directly and cannot fault. A fixed superpage window maps virtual to physical directly, but only in kernel mode. Its result is sign-extended on bit 40. All other valid addresses go through the buffer and its permission mask. After translation the physical address is checked for bits above the implemented width and for the uncached region, since fetching from uncached space is refused.

Top module: `fxl_fetch_xlate`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0 and `out_pa`, `out_fault` and `out_uncached` are 0.
- R2: `out_valid` is high exactly in the cycle after each cycle with `req_valid` high, and the result fields in that cycle belong to that request. Back-to-back requests give back-to-back results.
- R3: With `pc_priv` high the result is fault code 0 (none), `out_uncached` 0, and `out_pa` equal to `req_va[43:0]` with bits 1:0 cleared. This holds even for an invalid or superpage address, and no lookup is requested.
- R4: If `pc_priv` is low and `req_va[63:42]` is not all zeros or all ones, the fault is code 1 (access violation). This check ranks above every other fault.
- R5: A valid address with `req_va[47:41]` = 7'h7E is a superpage. In any mode other than kernel (`mode` = 0) it gives code 1.
- R6: A kernel superpage fetch forms the physical address from `req_va[39:0]`. If bit 40 is clear the address is that value zero-extended. If bit 40 is set, bits 43:40 are forced to 1. No low-bit clearing is applied.
- R7: `lookup_en` is high, in the request cycle, exactly for a valid request that is not privileged, has an address in range and is not a superpage. `lookup_vpn` is `req_va[42:13]` and `lookup_asn` is `asn`.
- R8: A lookup with `tlb_hit` low gives code 2 (page miss).
- R9: On a hit, the physical address is `tlb_ppn` shifted left by 13, ORed with `req_va[12:0]` with bits 1:0 cleared. If `tlb_xre[mode]` is 0 the fault is code 1, and this ranks above R10 and R11.
- R10: A formed physical address with any bit above bit 43 set gives code 3 (machine check).
- R11: Take a formed address with bit 43 set. If bits 43:20 are all ones it is register space: the result is code 4 (unimplemented), the address is unchanged and `out_uncached` is 0. Otherwise the result is code 4 with `out_uncached` 1 and bits 42:35 of the address cleared.
- R12: For fault codes 1, 2 and 3, `out_pa` is 0 and `out_uncached` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request strobe |
| req_va | input | 64 | Fetch virtual address |
| pc_priv | input | 1 | Fetch PC is in privileged code (PC bit 0 set) |
| mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| asn | input | 8 | Current address-space number |
| lookup_en | output | 1 | Buffer lookup wanted this cycle |
| lookup_vpn | output | 30 | Virtual page number to look up |
| lookup_asn | output | 8 | Address-space number to look up |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Physical page number of the hit |
| tlb_xre | input | 4 | Execute-permission mask, one bit per mode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 3 | 0 none, 1 access violation, 2 page miss, 3 machine check, 4 unimplemented |
| out_pa | output | 44 | Physical address |
| out_uncached | output | 1 | Address fell in uncached, non-register space |

## Verification
The superpage bit-40 sign extension and the uncached refusal can act on the same fetch. Forcing bits 43:40 high sets the uncached bit, so a kernel superpage address with bit 40 set must come out as an unimplemented fault. The bench sends one such address inside register space and one outside it. For the address outside, it compares the reported address after bits 42:35 are cleared and checks the uncached flag. In the same way, a permission failure and an out-of-range page number are sent together to judge that the access violation wins over the machine check.

// File: rtl/fxl_pkg.sv
`timescale 1ns/1ps
package fxl_pkg;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ACCESS = 3'd1,
        FLT_MISS   = 3'd2,
        FLT_MCHK   = 3'd3,
        FLT_UNIMP  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        M_KERNEL = 2'd0,
        M_EXEC   = 2'd1,
        M_SUPER  = 2'd2,
        M_USER   = 2'd3
    } mode_e;

    // Ones in bit positions hi..lo of a 64-bit word.
    function automatic logic [63:0] span_mask(input int hi, input int lo);
        logic [63:0] m;
        for (int b = 0; b < 64; b++) begin
            m[b] = (b >= lo) && (b <= hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/fxl_va_class.sv
`timescale 1ns/1ps
module fxl_va_class #(
    parameter int VA_BITS = 43,
    parameter int SP_HI   = 47,
    parameter int SP_LO   = 41,
    parameter logic [SP_HI-SP_LO:0] SP_TAG = 7'h7E
) (
    input  logic [63:SP_LO] va_hi,
    output logic            va_ok,
    output logic            is_super
);
    localparam int EXT_LO = VA_BITS - 1;

    logic [63:EXT_LO] ext;
    assign ext      = va_hi[63:EXT_LO];
    assign va_ok    = (&ext) | ~(|ext);
    assign is_super = va_ok && (va_hi[SP_HI:SP_LO] == SP_TAG);
endmodule

// File: rtl/fxl_pa_form.sv
`timescale 1ns/1ps
module fxl_pa_form
    import fxl_pkg::*;
#(
    parameter int PA_BITS    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32,
    parameter int SX_BIT     = 40
) (
    input  logic [PA_BITS-1:0] va_lo,
    input  logic               priv,
    input  logic               is_super,
    input  logic [PPN_W-1:0]   ppn,
    output logic [63:0]        pa_raw
);
    localparam logic [63:0] IMPL_MASK = span_mask(PA_BITS - 1, 0);
    localparam logic [63:0] SX_SET    = span_mask(PA_BITS - 1, SX_BIT);
    localparam logic [63:0] SX_KEEP   = span_mask(SX_BIT - 1, 0);

    logic [63:0] base;
    logic [63:0] pa_bypass;
    logic [63:0] pa_super;
    logic [63:0] pa_page;

    assign base      = {{(64-PA_BITS){1'b0}}, va_lo};
    assign pa_bypass = base & ~64'h3 & IMPL_MASK;
    assign pa_super  = va_lo[SX_BIT] ? ((base & IMPL_MASK) | SX_SET)
                                     : (base & SX_KEEP);
    assign pa_page   = {{(64-PPN_W-PAGE_SHIFT){1'b0}}, ppn, {PAGE_SHIFT{1'b0}}}
                     | {{(64-PAGE_SHIFT){1'b0}}, va_lo[PAGE_SHIFT-1:2], 2'b00};

    always_comb begin
        if (priv)          pa_raw = pa_bypass;
        else if (is_super) pa_raw = pa_super;
        else               pa_raw = pa_page;
    end
endmodule

// File: rtl/fxl_phys_chk.sv
`timescale 1ns/1ps
module fxl_phys_chk #(
    parameter int PA_BITS   = 44,
    parameter int RS_LO     = 20,
    parameter int UC_CLR_HI = 42,
    parameter int UC_CLR_LO = 35
) (
    input  logic [63:0]        pa_raw,
    output logic               mchk,
    output logic               uc_bit,
    output logic               reg_space,
    output logic [PA_BITS-1:0] pa_uc
);
    logic [PA_BITS-1:0] clr_mask;

    for (genvar b = 0; b < PA_BITS; b++) begin : g_clr
        assign clr_mask[b] = (b >= UC_CLR_LO) && (b <= UC_CLR_HI);
    end

    assign mchk      = |pa_raw[63:PA_BITS];
    assign uc_bit    = pa_raw[PA_BITS-1];
    assign reg_space = &pa_raw[PA_BITS-1:RS_LO];
    assign pa_uc     = pa_raw[PA_BITS-1:0] & ~clr_mask;
endmodule

// File: rtl/fxl_fetch_xlate.sv
`timescale 1ns/1ps
module fxl_fetch_xlate
    import fxl_pkg::*;
#(
    parameter int VA_BITS    = 43,
    parameter int PA_BITS    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_W      = 32,
    parameter int ASN_W      = 8,
    parameter int MODE_W     = 2,
    parameter int SP_HI      = 47,
    parameter int SP_LO      = 41,
    parameter int SX_BIT     = 40,
    parameter int RS_LO      = 20,
    parameter int UC_CLR_HI  = 42,
    parameter int UC_CLR_LO  = 35,
    localparam int VPN_W     = VA_BITS - PAGE_SHIFT,
    localparam int NMODES    = 2 ** MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [63:0]        req_va,
    input  logic               pc_priv,
    input  logic [MODE_W-1:0]  mode,
    input  logic [ASN_W-1:0]   asn,
    output logic               lookup_en,
    output logic [VPN_W-1:0]   lookup_vpn,
    output logic [ASN_W-1:0]   lookup_asn,
    input  logic               tlb_hit,
    input  logic [PPN_W-1:0]   tlb_ppn,
    input  logic [NMODES-1:0]  tlb_xre,
    output logic               out_valid,
    output logic [2:0]         out_fault,
    output logic [PA_BITS-1:0] out_pa,
    output logic               out_uncached
);
    logic               va_ok;
    logic               is_super;
    logic [63:0]        pa_raw;
    logic               mchk;
    logic               uc_bit;
    logic               reg_space;
    logic [PA_BITS-1:0] pa_uc;

    fault_e             nx_fault;
    logic [PA_BITS-1:0] nx_pa;
    logic               nx_unc;

    fxl_va_class #(
        .VA_BITS(VA_BITS), .SP_HI(SP_HI), .SP_LO(SP_LO)
    ) u_class (
        .va_hi   (req_va[63:SP_LO]),
        .va_ok   (va_ok),
        .is_super(is_super)
    );

    fxl_pa_form #(
        .PA_BITS(PA_BITS), .PAGE_SHIFT(PAGE_SHIFT),
        .PPN_W(PPN_W), .SX_BIT(SX_BIT)
    ) u_form (
        .va_lo   (req_va[PA_BITS-1:0]),
        .priv    (pc_priv),
        .is_super(is_super),
        .ppn     (tlb_ppn),
        .pa_raw  (pa_raw)
    );

    fxl_phys_chk #(
        .PA_BITS(PA_BITS), .RS_LO(RS_LO),
        .UC_CLR_HI(UC_CLR_HI), .UC_CLR_LO(UC_CLR_LO)
    ) u_phys (
        .pa_raw   (pa_raw),
        .mchk     (mchk),
        .uc_bit   (uc_bit),
        .reg_space(reg_space),
        .pa_uc    (pa_uc)
    );

    assign lookup_en  = req_valid && !pc_priv && va_ok && !is_super;
    assign lookup_vpn = req_va[VA_BITS-1:PAGE_SHIFT];
    assign lookup_asn = asn;

    // Fault priority: range, superpage mode, miss, permission, width, uncached.
    always_comb begin
        nx_fault = FLT_NONE;
        nx_pa    = '0;
        nx_unc   = 1'b0;
        if (pc_priv) begin
            nx_pa = pa_raw[PA_BITS-1:0];
        end else if (!va_ok) begin
            nx_fault = FLT_ACCESS;
        end else if (is_super && (mode != MODE_W'(M_KERNEL))) begin
            nx_fault = FLT_ACCESS;
        end else if (!is_super && !tlb_hit) begin
            nx_fault = FLT_MISS;
        end else if (!is_super && !tlb_xre[mode]) begin
            nx_fault = FLT_ACCESS;
        end else if (mchk) begin
            nx_fault = FLT_MCHK;
        end else if (uc_bit) begin
            nx_fault = FLT_UNIMP;
            if (reg_space) begin
                nx_pa = pa_raw[PA_BITS-1:0];
            end else begin
                nx_pa  = pa_uc;
                nx_unc = 1'b1;
            end
        end else begin
            nx_pa = pa_raw[PA_BITS-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_fault    <= FLT_NONE;
            out_pa       <= '0;
            out_uncached <= 1'b0;
        end else begin
            out_valid    <= req_valid;
            out_fault    <= nx_fault;
            out_pa       <= nx_pa;
            out_uncached <= nx_unc;
        end
    end
endmodule

// File: rtl/fxl_fetch_xlate_chk.sv
`timescale 1ns/1ps
module fxl_fetch_xlate_chk
    import fxl_pkg::*;
#(
    parameter int PA_BITS = 44
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               pc_priv,
    input logic               lookup_en,
    input logic               tlb_hit,
    input logic               out_valid,
    input logic [2:0]         out_fault,
    input logic [PA_BITS-1:0] out_pa,
    input logic               out_uncached
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    p_bypass_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && pc_priv) |=>
            (out_fault == FLT_NONE) && (out_pa[1:0] == 2'b00) && !out_uncached);

    p_bypass_no_lookup_r7: assert property (@(posedge clk) disable iff (rst)
        pc_priv |-> !lookup_en);

    p_miss_code_r8: assert property (@(posedge clk) disable iff (rst)
        (lookup_en && !tlb_hit) |=> (out_fault == FLT_MISS));

    p_uncached_unimp_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_uncached) |-> (out_fault == FLT_UNIMP));

    p_fault_pa_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ((out_fault == FLT_ACCESS) || (out_fault == FLT_MISS) ||
                       (out_fault == FLT_MCHK))) |-> (out_pa == '0) && !out_uncached);
endmodule

bind fxl_fetch_xlate fxl_fetch_xlate_chk #(.PA_BITS(PA_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .pc_priv     (pc_priv),
    .lookup_en   (lookup_en),
    .tlb_hit     (tlb_hit),
    .out_valid   (out_valid),
    .out_fault   (out_fault),
    .out_pa      (out_pa),
    .out_uncached(out_uncached)
);

// File: tb/fxl_fetch_xlate_tb_top.sv
`timescale 1ns/1ps
module fxl_fetch_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic        pc_priv = 1'b0;
    logic [1:0]  mode = '0;
    logic [7:0]  asn = '0;
    logic        lookup_en;
    logic [29:0] lookup_vpn;
    logic [7:0]  lookup_asn;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_xre = '0;
    logic        out_valid;
    logic [2:0]  out_fault;
    logic [43:0] out_pa;
    logic        out_uncached;

    always #2.5 clk = ~clk;

    fxl_fetch_xlate dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .pc_priv(pc_priv), .mode(mode), .asn(asn),
        .lookup_en(lookup_en), .lookup_vpn(lookup_vpn), .lookup_asn(lookup_asn),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre),
        .out_valid(out_valid), .out_fault(out_fault), .out_pa(out_pa),
        .out_uncached(out_uncached)
    );

    typedef struct {
        logic [2:0]  fault;
        logic [43:0] pa;
        logic        unc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] va, input logic priv, input logic [1:0] md,
                        input logic [7:0] a, input logic hit, input logic [31:0] ppn,
                        input logic [3:0] xre, input logic [2:0] ef, input logic [43:0] epa,
                        input logic eu, input logic elk, input logic [29:0] evpn,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; pc_priv = priv; mode = md; asn = a;
        tlb_hit = hit; tlb_ppn = ppn; tlb_xre = xre;
        e.fault = ef; e.pa = epa; e.unc = eu; e.tag = tag;
        exp_q.push_back(e);
        #0.5;
        check(lookup_en == elk, {tag, "/R7"}, "lookup_en", 64'(lookup_en), 64'(elk));
        if (elk) begin
            check(lookup_vpn == evpn && lookup_asn == a, {tag, "/R7"}, "lookup vpn",
                  64'(lookup_vpn), 64'(evpn));
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_valid == 1'b1, {e.tag, "/R2"}, "out_valid", 64'(out_valid), 64'd1);
                    check(out_fault == e.fault, e.tag, "fault", 64'(out_fault), 64'(e.fault));
                    check(out_pa == e.pa, e.tag, "pa", 64'(out_pa), 64'(e.pa));
                    check(out_uncached == e.unc, e.tag, "uncached",
                          64'(out_uncached), 64'(e.unc));
                end else begin
                    check(out_valid == 1'b0, "R2", "idle out_valid", 64'(out_valid), 64'd0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_pa == '0 && out_fault == 3'd0 && !out_uncached,
              "R1", "reset outputs", {19'd0, out_valid, out_pa}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_pa == '0, "R1", "first cycle after reset",
              {19'd0, out_valid, out_pa}, 64'd0);
        mon_on = 1'b1;

        // privileged bypass, in range and out of range
        send(64'h0000_0123_4567_89AB, 1, 2'd3, 8'h11, 0, 32'h0, 4'h0,
             3'd0, 44'h123_4567_89A8, 0, 0, 30'h0, "R3_bypass");
        send(64'h8000_0000_0000_1007, 1, 2'd3, 8'h11, 0, 32'h0, 4'h0,
             3'd0, 44'h000_0000_1004, 0, 0, 30'h0, "R3_bypass_badva");
        idle(1);
        // invalid virtual address
        send(64'h0000_0800_0000_0000, 0, 2'd0, 8'h11, 1, 32'h1, 4'hF,
             3'd1, 44'h0, 0, 0, 30'h0, "R4_badva");
        // superpage outside kernel
        send(64'hFFFF_FC00_1234_5678, 0, 2'd3, 8'h11, 1, 32'h1, 4'hF,
             3'd1, 44'h0, 0, 0, 30'h0, "R5_super_user");
        // superpage kernel, bit 40 clear
        send(64'hFFFF_FC12_3456_789A, 0, 2'd0, 8'h11, 0, 32'h0, 4'h0,
             3'd0, 44'h012_3456_789A, 0, 0, 30'h0, "R6_super_k");
        // superpage kernel, bit 40 set, outside register space
        send(64'hFFFF_FD00_1234_5678, 0, 2'd0, 8'h11, 0, 32'h0, 4'h0,
             3'd4, 44'h800_1234_5678, 1, 0, 30'h0, "R6_R11_super_uc");
        // superpage kernel, bit 40 set, register space
        send(64'hFFFF_FDFF_FFF0_0040, 0, 2'd0, 8'h11, 0, 32'h0, 4'h0,
             3'd4, 44'hFFF_FFF0_0040, 0, 0, 30'h0, "R11_regspace");
        idle(2);
        // miss
        send(64'h0000_0000_0004_6000, 0, 2'd0, 8'h05, 0, 32'h1234, 4'hF,
             3'd2, 44'h0, 0, 1, 30'h23, "R8_miss");
        // hit in kernel
        send(64'h0000_0000_0004_7ABF, 0, 2'd0, 8'h05, 1, 32'h1234, 4'b0001,
             3'd0, 44'h000_0246_9ABC, 0, 1, 30'h23, "R9_hit_k");
        // hit, user lacks permission
        send(64'h0000_0000_0004_7ABF, 0, 2'd3, 8'h05, 1, 32'h1234, 4'b0111,
             3'd1, 44'h0, 0, 1, 30'h23, "R9_perm");
        // hit, user permitted, top-of-range address
        send(64'hFFFF_FFFF_FFFF_E00F, 0, 2'd3, 8'h3C, 1, 32'h0ABC, 4'b1000,
             3'd0, 44'h000_0157_800C, 0, 1, 30'h3FFF_FFFF, "R9_hit_u");
        // machine check
        send(64'h0000_0000_0000_2000, 0, 2'd0, 8'h01, 1, 32'h8000_0000, 4'b0001,
             3'd3, 44'h0, 0, 1, 30'h1, "R10_mchk");
        // permission beats machine check
        send(64'h0000_0000_0000_2000, 0, 2'd0, 8'h01, 1, 32'h8000_0000, 4'b0000,
             3'd1, 44'h0, 0, 1, 30'h1, "R9_R12_perm_over_mchk");
        // mapped page in uncached space, bits 42:35 cleared
        send(64'h0000_0000_0000_0101, 0, 2'd1, 8'h02, 1, 32'h4FF0_0000, 4'b0010,
             3'd4, 44'h806_0000_0100, 1, 1, 30'h0, "R11_uc_page");
        idle(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule